// File: doc/BRIEF.md
# Thermal Clock Modulation Controller

This block protects a core from overheating. It does not stop the core clock outright. It gates the clock enable off and on at a fixed duty cycle. Throttling begins when the monitor is enabled and a fixed-threshold over-temperature comparator reports heat. The block modulates the clock in periods of `PERIOD_CYC` core cycles. Each period opens with an off-phase of `OFF_CYC` cycles. That off-phase is clamped so that it never exceeds `MAX_OFF_CYC`, the cycle count equivalent to 3.0 µs at the chosen core frequency.

When the comparator drops, a hysteresis timer of `HYST_CYC` cycles starts. Throttling ends only after that timer has expired, and only at the last cycle of an on-phase, so the core is never left with its clock gated. If the comparator reasserts while the timer runs, the timer is discarded and modulation continues without a gap. Interrupt requests that arrive during an off-phase are held. Each one is released as a single-cycle pulse on the first clock-on cycle.

All pins are plain control and status levels. No data flows through the block, so it has no valid/ready interface and no back-pressure. The trip threshold lives in the comparator outside the block, and no pin can change it.

Top module: `thermal_throttle_ctrl`

## Requirements
- R1: After reset, `core_clk_en` is 1, `throttle_active` is 0 and `irq_deliver` is 0.
- R2: If `mon_en` and `over_temp` are both 1 at a rising edge while the block is idle, then from that edge on `throttle_active` is 1 and an off-phase begins (`core_clk_en` = 0).
- R3: While throttling, `core_clk_en` repeats a pattern of `OFF_CYC` cycles at 0 followed by `PERIOD_CYC - OFF_CYC` cycles at 1.
- R4: No run of consecutive `core_clk_en` = 0 cycles is longer than `MAX_OFF_CYC`.
- R5: While `over_temp` and `mon_en` are 1, throttling does not end. After `over_temp` falls, `throttle_active` stays 1 for more than `HYST_CYC` cycles, and for at most `HYST_CYC + PERIOD_CYC + 1` cycles.
- R6: Throttling ends only after the last cycle of a complete on-phase, and `core_clk_en` stays 1 afterwards while `over_temp` is 0.
- R7: If `over_temp` rises again while the hysteresis timer runs, throttling continues without a break, and the full `HYST_CYC` wait restarts from the next fall.
- R8: A 1 on `irq_req` at a rising edge is held. It appears on `irq_deliver` as a one-cycle pulse in the first cycle with `core_clk_en` = 1. `irq_deliver` is never 1 while `core_clk_en` is 0.
- R9: While `mon_en` is 0, `core_clk_en` is 1 and `throttle_active` is 0 in the same cycle, whatever `over_temp` does. The controller returns to idle at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock (ungated) |
| rst_n | input | 1 | Active-low synchronous reset |
| mon_en | input | 1 | Enables thermal monitoring and throttling |
| over_temp | input | 1 | Over-temperature comparator output, fixed threshold |
| irq_req | input | 1 | Interrupt request, sampled each rising edge |
| core_clk_en | output | 1 | Clock enable to the core clock gate; 1 = clock runs |
| throttle_active | output | 1 | 1 while modulation is in force |
| irq_deliver | output | 1 | One-cycle pulse that releases a held interrupt during a clock-on cycle |

## Verification
The bound checker watches several properties on every cycle. It checks that no off-run exceeds the clamp and that an interrupt is never released while the clock is gated. It checks that a disabled monitor forces the clock on at once and that throttling never starts without heat. It also checks that a hot, enabled block keeps throttling and that every exit falls on a clock-on cycle. Other properties need a known history, so only the bench scenarios show them. These are the exact off and on counts of each period, the minimum hysteresis delay before exit, and the restart of that delay after the temperature reasserts. The bench also measures that the exit closes a full on-phase and that a held interrupt surfaces on the first on-cycle as a single pulse.

// File: rtl/tt_pkg.sv
package tt_pkg;
  typedef enum logic [1:0] {
    TT_IDLE = 2'd0,
    TT_HOT  = 2'd1,
    TT_COOL = 2'd2
  } tt_state_e;
endpackage

// File: rtl/tt_phase_gen.sv
// Modulation phase counter: off-phase first, then on-phase.
module tt_phase_gen #(
  parameter int PERIOD_CYC = 10,
  parameter int OFF_CYC    = 4,
  localparam int PH_W      = (PERIOD_CYC > 1) ? $clog2(PERIOD_CYC) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic phase_off,
  output logic phase_last
);
  localparam logic [PH_W-1:0] LAST_V = PH_W'(PERIOD_CYC - 1);
  localparam logic [PH_W-1:0] OFF_V  = PH_W'(OFF_CYC);

  logic [PH_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt_q <= '0;
    else if (cnt_q == LAST_V) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  assign phase_off  = run && (cnt_q < OFF_V);
  assign phase_last = run && (cnt_q == LAST_V);
endmodule

// File: rtl/tt_hyst_timer.sv
// Counts cool cycles; saturates at HYST_CYC and reports expiry.
module tt_hyst_timer #(
  parameter int HYST_CYC = 6,
  localparam int HW      = $clog2(HYST_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic count,
  output logic expired
);
  localparam logic [HW-1:0] LIM_V = HW'(HYST_CYC);
  logic [HW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) cnt_q <= '0;
    else if (count && cnt_q != LIM_V) cnt_q <= cnt_q + 1'b1;
  end

  assign expired = (cnt_q == LIM_V);
endmodule

// File: rtl/tt_irq_hold.sv
// Holds an interrupt until a clock-on cycle releases it.
module tt_irq_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_req,
  input  logic clk_on,
  output logic irq_out
);
  logic pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= 1'b0;
    else pend_q <= irq_req || (pend_q && !clk_on);
  end

  assign irq_out = pend_q && clk_on;
endmodule

// File: rtl/thermal_throttle_ctrl.sv
module thermal_throttle_ctrl #(
  parameter int PERIOD_CYC  = 10,
  parameter int OFF_CYC     = 4,
  parameter int MAX_OFF_CYC = 600,
  parameter int HYST_CYC    = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mon_en,
  input  logic over_temp,
  input  logic irq_req,
  output logic core_clk_en,
  output logic throttle_active,
  output logic irq_deliver
);
  import tt_pkg::*;

  localparam int OFF_CLAMP = (OFF_CYC > MAX_OFF_CYC) ? MAX_OFF_CYC : OFF_CYC;
  localparam int OFF_EFF   = (OFF_CLAMP >= PERIOD_CYC) ? PERIOD_CYC - 1 : OFF_CLAMP;

  tt_state_e state_q, state_d;
  logic      run, phase_off, phase_last, hyst_done;

  assign run = mon_en && (state_q != TT_IDLE);

  tt_phase_gen #(.PERIOD_CYC(PERIOD_CYC), .OFF_CYC(OFF_EFF)) u_phase (
    .clk(clk), .rst_n(rst_n), .run(run),
    .phase_off(phase_off), .phase_last(phase_last)
  );

  tt_hyst_timer #(.HYST_CYC(HYST_CYC)) u_hyst (
    .clk(clk), .rst_n(rst_n),
    .clear(state_q != TT_COOL || over_temp),
    .count(state_q == TT_COOL),
    .expired(hyst_done)
  );

  always_comb begin
    state_d = state_q;
    if (!mon_en) state_d = TT_IDLE;
    else begin
      case (state_q)
        TT_IDLE: if (over_temp) state_d = TT_HOT;
        TT_HOT:  if (!over_temp) state_d = TT_COOL;
        TT_COOL: begin
          if (over_temp) state_d = TT_HOT;
          else if (hyst_done && phase_last) state_d = TT_IDLE;
        end
        default: state_d = TT_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= TT_IDLE;
    else state_q <= state_d;
  end

  assign core_clk_en     = !(mon_en && phase_off);
  assign throttle_active = run;

  tt_irq_hold u_irq (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req),
    .clk_on(core_clk_en), .irq_out(irq_deliver)
  );
endmodule

// File: rtl/thermal_throttle_ctrl_chk.sv
module thermal_throttle_ctrl_chk #(
  parameter int MAX_OFF_CYC = 600
) (
  input logic clk,
  input logic rst_n,
  input logic mon_en,
  input logic over_temp,
  input logic core_clk_en,
  input logic throttle_active,
  input logic irq_deliver
);
  localparam int RW = $clog2(MAX_OFF_CYC + 2);
  logic [RW-1:0] off_run_q;

  always_ff @(posedge clk) begin
    if (!rst_n || core_clk_en) off_run_q <= '0;
    else if (off_run_q != RW'(MAX_OFF_CYC + 1)) off_run_q <= off_run_q + 1'b1;
  end

  p_off_bounded_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !core_clk_en |-> (off_run_q < RW'(MAX_OFF_CYC)));

  p_irq_only_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_deliver |-> core_clk_en);

  p_disabled_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !mon_en |-> (core_clk_en && !throttle_active));

  p_start_needs_heat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(throttle_active) |-> $past(over_temp && mon_en));

  p_hold_while_hot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (throttle_active && over_temp && mon_en) |=> throttle_active);

  p_exit_on_phase_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(throttle_active) && mon_en) |-> ($past(core_clk_en) && core_clk_en));
endmodule

bind thermal_throttle_ctrl thermal_throttle_ctrl_chk #(.MAX_OFF_CYC(MAX_OFF_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .mon_en(mon_en), .over_temp(over_temp),
  .core_clk_en(core_clk_en), .throttle_active(throttle_active),
  .irq_deliver(irq_deliver)
);

// File: tb/thermal_throttle_ctrl_bench.sv
`timescale 1ns/1ps
module thermal_throttle_ctrl_bench;
  localparam int PERIOD = 10;
  localparam int OFFC   = 4;
  localparam int MAXOFF = 600;
  localparam int HYST   = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mon_en = 1'b1, over_temp = 1'b0, irq_req = 1'b0;
  logic core_clk_en, throttle_active, irq_deliver;
  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  thermal_throttle_ctrl #(.PERIOD_CYC(PERIOD), .OFF_CYC(OFFC),
                          .MAX_OFF_CYC(MAXOFF), .HYST_CYC(HYST)) u_thermal_throttle_ctrl (
    .clk(clk), .rst_n(rst_n), .mon_en(mon_en), .over_temp(over_temp),
    .irq_req(irq_req), .core_clk_en(core_clk_en),
    .throttle_active(throttle_active), .irq_deliver(irq_deliver)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic cool_down();
    over_temp = 1'b0;
    for (int i = 0; i < 200 && throttle_active; i++) step();
    step();
  endtask

  task automatic t_reset();
    check(core_clk_en == 1'b1, "R1 clk_en", core_clk_en, 1);
    check(throttle_active == 1'b0, "R1 active", throttle_active, 0);
    check(irq_deliver == 1'b0, "R1 irq", irq_deliver, 0);
  endtask

  task automatic t_duty();
    int run_off = 0, max_off = 0;
    over_temp = 1'b1;
    step();
    check(throttle_active == 1'b1, "R2 active", throttle_active, 1);
    check(core_clk_en == 1'b0, "R2 first off", core_clk_en, 0);
    for (int p = 0; p < 3; p++) begin
      for (int k = 0; k < PERIOD; k++) begin
        check(core_clk_en == (k >= OFFC), "R3 pattern", core_clk_en, int'(k >= OFFC));
        if (!core_clk_en) run_off++; else run_off = 0;
        if (run_off > max_off) max_off = run_off;
        step();
      end
    end
    check(max_off <= MAXOFF && max_off == OFFC, "R4 off run", max_off, OFFC);
    cool_down();
  endtask

  task automatic t_exit();
    int on_run = 0, n = 0, last_run = 0;
    bit last_en = 1'b0;
    over_temp = 1'b1;
    step();
    for (int i = 0; i < 13; i++) begin
      if (core_clk_en) on_run++; else on_run = 0;
      step();
    end
    over_temp = 1'b0;
    while (throttle_active && n < 100) begin
      if (core_clk_en) on_run++; else on_run = 0;
      last_en = core_clk_en; last_run = on_run;
      step(); n++;
    end
    check(n > HYST, "R5 min hyst", n, HYST + 1);
    check(n <= HYST + PERIOD + 1, "R5 max exit", n, HYST + PERIOD + 1);
    check(last_en == 1'b1, "R6 last on", last_en, 1);
    check(last_run == PERIOD - OFFC, "R6 full on-phase", last_run, PERIOD - OFFC);
    begin
      int bad = 0;
      for (int i = 0; i < 2 * PERIOD; i++) begin
        if (!core_clk_en || throttle_active) bad++;
        step();
      end
      check(bad == 0, "R6 clock stays on", bad, 0);
    end
  endtask

  task automatic t_reassert();
    int gaps = 0, n = 0;
    over_temp = 1'b1;
    step();
    for (int i = 0; i < 5; i++) step();
    over_temp = 1'b0;
    for (int i = 0; i < HYST - 2; i++) begin
      step(); if (!throttle_active) gaps++;
    end
    over_temp = 1'b1;
    step(); if (!throttle_active) gaps++;
    over_temp = 1'b0;
    while (throttle_active && n < 100) begin step(); n++; end
    check(gaps == 0, "R7 no gap", gaps, 0);
    check(n > HYST, "R7 timer restarted", n, HYST + 1);
    step();
  endtask

  task automatic t_irq_off();
    int leaks = 0;
    over_temp = 1'b1;
    step();
    irq_req = 1'b1;
    step();
    irq_req = 1'b0;
    check(core_clk_en == 1'b0, "R8 still off", core_clk_en, 0);
    for (int i = 0; i < PERIOD && !core_clk_en; i++) begin
      if (irq_deliver) leaks++;
      step();
    end
    check(leaks == 0, "R8 held while off", leaks, 0);
    check(irq_deliver == 1'b1 && core_clk_en, "R8 released on", irq_deliver, 1);
    step();
    check(irq_deliver == 1'b0, "R8 single pulse", irq_deliver, 0);
    cool_down();
  endtask

  task automatic t_irq_idle();
    irq_req = 1'b1;
    step();
    irq_req = 1'b0;
    check(irq_deliver == 1'b1, "R8 idle pass", irq_deliver, 1);
    step();
    check(irq_deliver == 1'b0, "R8 idle clear", irq_deliver, 0);
  endtask

  task automatic t_disable();
    int bad = 0;
    mon_en = 1'b0; over_temp = 1'b1;
    for (int i = 0; i < 30; i++) begin
      step(); if (!core_clk_en || throttle_active) bad++;
    end
    check(bad == 0, "R9 disabled", bad, 0);
    mon_en = 1'b1;
    step();
    check(throttle_active == 1'b1, "R9 enable trips", throttle_active, 1);
    check(core_clk_en == 1'b0, "R9 enable off", core_clk_en, 0);
    mon_en = 1'b0; #1;
    check(core_clk_en == 1'b1, "R9 immediate clk", core_clk_en, 1);
    check(throttle_active == 1'b0, "R9 immediate status", throttle_active, 0);
    step();
    over_temp = 1'b0; mon_en = 1'b1;
    step(); step();
    check(throttle_active == 1'b0 && core_clk_en, "R9 back idle", throttle_active, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step();
    t_reset();
    t_duty();
    t_exit();
    t_reassert();
    t_irq_off();
    t_irq_idle();
    t_disable();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule